// File: doc/BRIEF.md
# Four-Condition Interrupting GPIO Port

A 32-pin general-purpose I/O port controlled through a small word-addressed register bus. Reads are combinational from the address. Writes take effect on the clock edge where the write enable is high. Each pin can drive its pad, with an output enable, a pull-up enable and a drive-strength bit. It can also hand its pad to one of two alternate data sources, and its final output can be inverted.

On the input side, every pad is synchronized through two flops. The synchronized level then feeds four independent detectors per pin: rising edge, falling edge, high level and low level. Each detector has its own pending bit. Software clears a pending bit by writing a one to its position. A level condition that still holds sets its pending bit again at once.

The four pending bits of a pin, each gated by its own enable bit, are ORed into a dedicated interrupt line for that pin. The port is meant to sit between the pad ring and an external interrupt controller, with one source wired to each pin.

Top module: `gpio_cond_port`

## Requirements
- R1: After reset, every writable register reads 0 and all pending bits are 0. As a result, `pad_oe_o`, `pad_pu_o`, `pad_ds_o`, `pad_out_o` and `irq_o` are all 0.
- R2: The register word addresses are:
  - 0: input value (read-only)
  - 1: input enable
  - 2: output enable
  - 3: output value
  - 4: pull-up
  - 5: drive strength
  - 6 / 7: rise enable / rise pending
  - 8 / 9: fall enable / fall pending
  - 10 / 11: high enable / high pending
  - 12 / 13: low enable / low pending
  - 14: alternate enable
  - 15: alternate select
  - 16: invert

  A write lands on the clock edge where `we_i` is high and is visible on `rdata_o` after that edge. Writes to address 0 or to addresses above 16 change nothing, and addresses above 16 read 0.
- R3: The input value word returns the pad level delayed by two clock edges, with each bit forced to 0 where its input enable bit is 0.
- R4: A 0-to-1 pad transition sets the pin's rise pending and high pending bits. A 1-to-0 transition sets its fall pending and low pending bits. In both cases the bits set on the third clock edge after the pad changes.
- R5: Writing a pending word clears exactly the bits written as 1. Bits written as 0 are left unchanged.
- R6: A high (low) pending bit that is cleared while the synchronized pin is still high (low) reads as set again on the next cycle.
- R7: When a clear write and a new rise condition on the same bit land on the same edge, the pending bit ends up set.
- R8: `irq_o[i]` is 1 exactly when, for at least one of the four conditions, both the pending bit and the enable bit of pin i are 1. Pending bits record conditions whatever their enable.
- R9: The pad output equals (alternate enable ? (alternate select ? `alt1_i` : `alt0_i`) : output value) XOR invert. `pad_oe_o`, `pad_pu_o` and `pad_ds_o` follow the output-enable, pull-up and drive-strength registers.
- R10: The output value can be written while the output enable is 0, and the preset level appears on `pad_out_o`. Turning the enable on afterwards leaves `pad_out_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Register word address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| pad_in_i | input | 32 | Pad input levels (asynchronous) |
| alt0_i | input | 32 | Alternate source 0 output data |
| alt1_i | input | 32 | Alternate source 1 output data |
| pad_out_o | output | 32 | Pad output data |
| pad_oe_o | output | 32 | Pad output enable |
| pad_pu_o | output | 32 | Pad pull-up enable |
| pad_ds_o | output | 32 | Pad drive strength select |
| irq_o | output | 32 | Per-pin interrupt |

## Verification
The bench measures the edge-detection latency exactly. It reads rise pending one cycle before and on the cycle it must set, so an extra or missing synchronizer stage shows as a wrong value.

It clears a level-pending bit while the level persists. A design that lets the bit drop would read 0 there.

It times a clear write to collide with a fresh rising edge. A design where the clear wins would lose the event.

It also writes pending words with zeros over set bits, enables conditions one at a time to watch each interrupt line follow, and walks a vector table through the output mux with invert and alternate selection mixed per bit. A swapped select or a dropped XOR corrupts specific bytes.

// File: rtl/gpio_cond_pkg.sv
package gpio_cond_pkg;
  localparam int unsigned ADDR_W      = 5;
  localparam int unsigned NCOND       = 4;
  localparam int unsigned NREG        = 17;
  // condition indices
  localparam int unsigned C_RISE      = 0;
  localparam int unsigned C_FALL      = 1;
  localparam int unsigned C_HIGH      = 2;
  localparam int unsigned C_LOW       = 3;
  // word addresses
  localparam logic [ADDR_W-1:0] A_IN_VAL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_IN_EN   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_OUT_EN  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_OUT_VAL = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_PULL    = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_DRIVE   = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_ALT_EN  = ADDR_W'(14);
  localparam logic [ADDR_W-1:0] A_ALT_SEL = ADDR_W'(15);
  localparam logic [ADDR_W-1:0] A_INVERT  = ADDR_W'(16);
  localparam int unsigned IE_BASE     = 6;
  localparam int unsigned IP_BASE     = 7;
  localparam int unsigned COND_STRIDE = 2;

  function automatic logic [ADDR_W-1:0] ie_addr(input int unsigned k);
    return ADDR_W'(IE_BASE + COND_STRIDE * k);
  endfunction

  function automatic logic [ADDR_W-1:0] ip_addr(input int unsigned k);
    return ADDR_W'(IP_BASE + COND_STRIDE * k);
  endfunction
endpackage

// File: rtl/gcp_sync.sv
module gcp_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st[0] <= '0;
    else         st[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st[g] <= '0;
      else         st[g] <= st[g-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/gcp_detect.sv
module gcp_detect import gpio_cond_pkg::*; #(
  parameter int unsigned W = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [W-1:0]              lvl_i,
  input  logic [NCOND-1:0][W-1:0]   clr_i,
  output logic [NCOND-1:0][W-1:0]   pend_o,
  output logic [W-1:0]              lvl_q_o
);
  logic [W-1:0]            lvl_q;
  logic [NCOND-1:0][W-1:0] cond, pend_q;

  always_comb begin
    cond[C_RISE] = lvl_i & ~lvl_q;
    cond[C_FALL] = ~lvl_i & lvl_q;
    cond[C_HIGH] = lvl_i;
    cond[C_LOW]  = ~lvl_i;
  end

  // new condition wins over a same-edge clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= '0;
      pend_q <= '0;
    end else begin
      lvl_q <= lvl_i;
      for (int k = 0; k < NCOND; k++)
        pend_q[k] <= (pend_q[k] & ~clr_i[k]) | cond[k];
    end
  end

  assign pend_o  = pend_q;
  assign lvl_q_o = lvl_q;
endmodule

// File: rtl/gcp_outmux.sv
module gcp_outmux #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] out_val_i,
  input  logic [W-1:0] alt_en_i,
  input  logic [W-1:0] alt_sel_i,
  input  logic [W-1:0] alt0_i,
  input  logic [W-1:0] alt1_i,
  input  logic [W-1:0] inv_i,
  output logic [W-1:0] pad_out_o
);
  for (genvar g = 0; g < W; g++) begin : g_pin
    logic src;
    assign src          = alt_en_i[g] ? (alt_sel_i[g] ? alt1_i[g] : alt0_i[g]) : out_val_i[g];
    assign pad_out_o[g] = src ^ inv_i[g];
  end
endmodule

// File: rtl/gpio_cond_port.sv
module gpio_cond_port import gpio_cond_pkg::*; #(
  parameter int unsigned NPIN        = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [NPIN-1:0]   wdata_i,
  output logic [NPIN-1:0]   rdata_o,
  input  logic [NPIN-1:0]   pad_in_i,
  input  logic [NPIN-1:0]   alt0_i,
  input  logic [NPIN-1:0]   alt1_i,
  output logic [NPIN-1:0]   pad_out_o,
  output logic [NPIN-1:0]   pad_oe_o,
  output logic [NPIN-1:0]   pad_pu_o,
  output logic [NPIN-1:0]   pad_ds_o,
  output logic [NPIN-1:0]   irq_o
);
  logic [NPIN-1:0] in_en_q, out_en_q, out_val_q, pue_q, ds_q;
  logic [NPIN-1:0] alt_en_q, alt_sel_q, inv_q;
  logic [NCOND-1:0][NPIN-1:0] ie_q, pend, clr;
  logic [NPIN-1:0] lvl_s, lvl_q;

  gcp_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_in_i), .q_o(lvl_s)
  );

  always_comb begin
    for (int k = 0; k < NCOND; k++)
      clr[k] = (we_i && addr_i == ip_addr(k)) ? wdata_i : '0;
  end

  gcp_detect #(.W(NPIN)) u_det (
    .clk_i, .rst_ni, .lvl_i(lvl_s), .clr_i(clr), .pend_o(pend), .lvl_q_o(lvl_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_en_q   <= '0;
      out_en_q  <= '0;
      out_val_q <= '0;
      pue_q     <= '0;
      ds_q      <= '0;
      alt_en_q  <= '0;
      alt_sel_q <= '0;
      inv_q     <= '0;
      ie_q      <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_IN_EN:   in_en_q   <= wdata_i;
        A_OUT_EN:  out_en_q  <= wdata_i;
        A_OUT_VAL: out_val_q <= wdata_i;
        A_PULL:    pue_q     <= wdata_i;
        A_DRIVE:   ds_q      <= wdata_i;
        A_ALT_EN:  alt_en_q  <= wdata_i;
        A_ALT_SEL: alt_sel_q <= wdata_i;
        A_INVERT:  inv_q     <= wdata_i;
        default: ;
      endcase
      for (int k = 0; k < NCOND; k++)
        if (addr_i == ie_addr(k)) ie_q[k] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_IN_VAL:  rdata_o = lvl_s & in_en_q;
      A_IN_EN:   rdata_o = in_en_q;
      A_OUT_EN:  rdata_o = out_en_q;
      A_OUT_VAL: rdata_o = out_val_q;
      A_PULL:    rdata_o = pue_q;
      A_DRIVE:   rdata_o = ds_q;
      A_ALT_EN:  rdata_o = alt_en_q;
      A_ALT_SEL: rdata_o = alt_sel_q;
      A_INVERT:  rdata_o = inv_q;
      default: ;
    endcase
    for (int k = 0; k < NCOND; k++) begin
      if (addr_i == ie_addr(k)) rdata_o = ie_q[k];
      if (addr_i == ip_addr(k)) rdata_o = pend[k];
    end
  end

  always_comb begin
    irq_o = '0;
    for (int k = 0; k < NCOND; k++) irq_o = irq_o | (pend[k] & ie_q[k]);
  end

  gcp_outmux #(.W(NPIN)) u_mux (
    .out_val_i(out_val_q), .alt_en_i(alt_en_q), .alt_sel_i(alt_sel_q),
    .alt0_i, .alt1_i, .inv_i(inv_q), .pad_out_o
  );

  assign pad_oe_o = out_en_q;
  assign pad_pu_o = pue_q;
  assign pad_ds_o = ds_q;
endmodule

// File: rtl/gcp_checker.sv
module gcp_checker import gpio_cond_pkg::*; #(
  parameter int unsigned W = 32
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    we_i,
  input logic [ADDR_W-1:0]       addr_i,
  input logic [W-1:0]            wdata_i,
  input logic [W-1:0]            rdata_o,
  input logic [W-1:0]            irq_o,
  input logic [W-1:0]            lvl,
  input logic [W-1:0]            lvl_q,
  input logic [NCOND-1:0][W-1:0] pend,
  input logic [NCOND-1:0][W-1:0] ie,
  input logic [W-1:0]            in_en
);
  p_rise_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(lvl & ~lvl_q)) |=> ((pend[C_RISE] & $past(lvl & ~lvl_q)) == $past(lvl & ~lvl_q)));

  p_fall_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(~lvl & lvl_q)) |=> ((pend[C_FALL] & $past(~lvl & lvl_q)) == $past(~lvl & lvl_q)));

  p_high_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lvl) |=> ((pend[C_HIGH] & $past(lvl)) == $past(lvl)));

  p_low_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(~lvl)) |=> ((pend[C_LOW] & $past(~lvl)) == $past(~lvl)));

  p_rise_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == ip_addr(C_RISE)) |=> ((pend[C_RISE] & $past(pend[C_RISE])) == $past(pend[C_RISE])));

  p_clear_vs_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ip_addr(C_RISE) && |(wdata_i & lvl & ~lvl_q))
    |=> ((pend[C_RISE] & $past(wdata_i & lvl & ~lvl_q)) == $past(wdata_i & lvl & ~lvl_q)));

  p_irq_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~(ie[0] | ie[1] | ie[2] | ie[3])) == '0);

  p_in_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_IN_VAL) |-> ((rdata_o & ~in_en) == '0));
endmodule

bind gpio_cond_port gcp_checker #(.W(NPIN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .rdata_o(rdata_o), .irq_o(irq_o), .lvl(lvl_s), .lvl_q(lvl_q), .pend(pend),
  .ie(ie_q), .in_en(in_en_q)
);

// File: tb/sim_gpio_cond_port.sv
module sim_gpio_cond_port;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // out_val, invert, alt_en, alt_sel, alt0, alt1, expected pad_out
  localparam logic [31:0] VEC [NV][7] = '{
    '{32'hF0F0F0F0, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000, 32'hF0F0F0F0},
    '{32'hF0F0F0F0, 32'hFFFF0000, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000, 32'h0F0FF0F0},
    '{32'h00000000, 32'h00000000, 32'h0000FFFF, 32'h00000000, 32'h12345678, 32'h9ABCDEF0, 32'h00005678},
    '{32'hAAAAAAAA, 32'h00000000, 32'hFFFF0000, 32'hFFFFFFFF, 32'h00000000, 32'h9ABCDEF0, 32'h9ABCAAAA},
    '{32'h00000000, 32'h000000FF, 32'hFFFFFFFF, 32'h0000FF00, 32'h12345678, 32'h9ABCDEF0, 32'h1234DE87},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0, rdata, pad_in = '0, alt0 = '0, alt1 = '0;
  logic [31:0] pad_out, pad_oe, pad_pu, pad_ds, irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_cond_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata), .rdata_o(rdata),
    .pad_in_i(pad_in), .alt0_i(alt0), .alt1_i(alt1), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .pad_pu_o(pad_pu), .pad_ds_o(pad_ds), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%08h exp=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    addr = 5'(a); wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = 5'(a);
    #1 d = rdata;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] v;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    // reset state
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 pad_pu", pad_pu, 0);
    chk("R1 pad_ds", pad_ds, 0);
    chk("R1 pad_out", pad_out, 0);
    chk("R1 irq", irq, 0);
    rd(1, v);  chk("R1 in_en", v, 0);
    rd(6, v);  chk("R1 rise_ie", v, 0);
    rd(16, v); chk("R1 invert", v, 0);
    rd(7, v);  chk("R1 rise_pend", v, 0);

    // register map
    wr(1, 32'hFFFFFFFF); rd(1, v); chk("R2 in_en rb", v, 32'hFFFFFFFF);
    wr(0, 32'h12345678); rd(0, v); chk("R2 in_val ro", v, 0);
    wr(20, 32'hDEAD);    rd(20, v); chk("R2 unmapped", v, 0);
    wr(5, 32'h33);       rd(5, v); chk("R2 drive rb", v, 32'h33);
    chk("R9 pad_ds", pad_ds, 32'h33);

    // synchronizer latency and input gating
    pad_in = 32'hA5A50F0F;
    tick(1); rd(0, v); chk("R3 one edge", v, 0);
    tick(1); rd(0, v); chk("R3 two edges", v, 32'hA5A50F0F);
    wr(1, 32'h0000FFFF); rd(0, v); chk("R3 gated", v, 32'h00000F0F);
    wr(1, 32'hFFFFFFFF);
    pad_in = '0;
    tick(4);
    wr(7, '1); wr(9, '1); wr(11, '1); wr(13, '1);
    rd(13, v); chk("R6 low reasserts", v, 32'hFFFFFFFF);
    rd(11, v); chk("R5 high cleared", v, 0);
    rd(9, v);  chk("R5 fall cleared", v, 0);

    // rising and falling edges
    pad_in = 32'h8;
    tick(2); rd(7, v); chk("R4 rise early", v, 0);
    tick(1); rd(7, v); chk("R4 rise set", v, 32'h8);
    rd(11, v); chk("R4 high set", v, 32'h8);
    rd(9, v);  chk("R4 no fall", v, 0);
    pad_in = '0;
    tick(3); rd(9, v); chk("R4 fall set", v, 32'h8);
    rd(13, v); chk("R4 low set", v, 32'hFFFFFFFF);
    wr(7, 32'h8);  rd(7, v);  chk("R5 rise clr", v, 0);
    wr(11, 32'h8); rd(11, v); chk("R5 high clr", v, 0);
    wr(9, 32'h0);  rd(9, v);  chk("R5 zero write", v, 32'h8);
    wr(9, 32'hFFFFFFF7); rd(9, v); chk("R5 other bits", v, 32'h8);
    wr(9, 32'h8);  rd(9, v);  chk("R5 fall clr", v, 0);

    // high level re-assert
    pad_in = 32'h10;
    tick(3);
    wr(11, 32'h10); rd(11, v); chk("R6 high reasserts", v, 32'h10);
    wr(7, 32'h10);  rd(7, v);  chk("R6 rise clr", v, 0);

    // clear colliding with a new rise on bit 9
    pad_in = 32'h210;
    tick(2);
    wr(7, 32'h200); rd(7, v); chk("R7 edge wins", v, 32'h200);
    wr(7, 32'h200); rd(7, v); chk("R7 later clear", v, 0);

    // interrupt gating
    pad_in = 32'h230;
    tick(3); rd(7, v); chk("R8 pend w/o enable", v, 32'h20);
    chk("R8 no irq", irq, 0);
    wr(6, 32'h20);  chk("R8 rise irq", irq, 32'h20);
    wr(12, 32'h1);  chk("R8 low irq", irq, 32'h21);
    wr(7, 32'h20);  chk("R8 clr drops", irq, 32'h1);
    wr(12, 32'h0);  chk("R8 low off", irq, 0);
    wr(10, 32'h10); chk("R8 high irq", irq, 32'h10);
    wr(11, 32'h10); chk("R6 irq stays", irq, 32'h10);
    wr(10, 32'h0); wr(6, 32'h0);
    chk("R8 all off", irq, 0);

    // preset before drive
    wr(3, 32'h4);
    chk("R10 preset out", pad_out, 32'h4);
    chk("R10 oe off", pad_oe, 0);
    wr(2, 32'h4);
    chk("R10 oe on", pad_oe, 32'h4);
    chk("R10 out held", pad_out, 32'h4);
    wr(4, 32'h81); chk("R9 pull-up", pad_pu, 32'h81);

    // output mux table
    for (int i = 0; i < NV; i++) begin
      wr(3, VEC[i][0]); wr(16, VEC[i][1]); wr(14, VEC[i][2]); wr(15, VEC[i][3]);
      alt0 = VEC[i][4]; alt1 = VEC[i][5];
      #1 chk("R9 mux row", pad_out, VEC[i][6]);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule